// File: doc/BRIEF.md
# Dual-Channel Compare Timer

This block is a memory-mapped timer with two identical channels. Both channels sit behind a simple 32-bit register bus. Each channel owns a 32-bit up-counter, a compare value and a small control word. The control word combines three things: a count enable, an interrupt enable and a pending flag that software clears by writing one to it.

In normal use the first channel runs freely as a time base that software reads. The second is armed as a one-shot event timer:

- software stops it;
- it zeroes the counter;
- it loads a compare value;
- it enables counting with the interrupt enabled.

When the counter reaches the compare value, the pending flag is raised and the channel's interrupt line goes high. The line stays high until software clears the flag or drops the interrupt enable.

The bus has a request side and a response side.

- **Requests:** a request is presented with `req_valid` and is always accepted in the cycle it is presented. There is no back-pressure on requests. A write takes effect at that clock edge.
- **Read responses:** a read returns its data one cycle later with `rsp_valid` high for exactly one cycle. The response cannot be stalled, so the requester must take it in that cycle.

Top module: `dual_cmp_timer`

## Requirements
- R1: Channel register blocks start at byte offset 0x08 (channel 0) and 0x14 (channel 1). Within each block, control is at +0x0, compare at +0x4 and counter value at +0x8. The compare register reads back the value last written.
- R2: The control word has the pending flag in bit 0, the interrupt enable in bit 1 and the count enable in bit 2. Bits 31..3 read as zero. Writes set bits 1 and 2 directly.
- R3: While count enable is set, the counter increases by one on every clock; while it is clear, the counter holds its value.
- R4: A write to the counter value register loads the written data into the counter, taking precedence over the increment in that cycle.
- R5: When count enable is set and the counter equals the compare value, the pending flag is set at the next edge. The counter keeps counting past the match. The flag is set whether or not the interrupt enable is set.
- R6: The counter wraps from 0xFFFFFFFF to 0 and can match a compare value after wrapping.
- R7: Writing a control word with bit 0 set clears the pending flag. Writing bit 0 as zero leaves the flag unchanged.
- R8: A compare match and a clearing write to the same channel in the same cycle leave the pending flag set.
- R9: Each channel's interrupt output is a level equal to its pending flag AND its interrupt enable.
- R10: A read returns data one cycle after the request, with `rsp_valid` high for one cycle. Addresses outside the six mapped words (including misaligned ones) read as zero, and writes to them have no effect.
- R11: After reset all control, compare and counter registers are zero and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | N_CH | Per-channel interrupt level (bit 0 = channel 0) |

## Verification
The delicate overlap is a compare match landing in the same cycle as a software write that clears the pending flag. The bench arms the event channel with a zeroed counter and a small compare value. It counts clock edges from the enabling write so that the clearing write lands exactly on the match edge. A following control read must still show the flag set. In contrast, a clearing write one cycle away from a match must leave it clear, and a write with bit 0 at zero must leave it set. Expected counter values are derived from the number of edges the counter has run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DW = 32;

  // register offsets within a channel block
  localparam int OFS_CTL = 0;
  localparam int OFS_CMP = 4;
  localparam int OFS_VAL = 8;

  // control word bit positions
  localparam int BIT_PEND = 0;
  localparam int BIT_IEN  = 1;
  localparam int BIT_CEN  = 2;

  typedef struct packed {
    logic cen;
    logic ien;
    logic pend;
  } ctl_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int ADDR_W = 8,
  parameter int N_CH   = 2,
  parameter int BASE0  = 8,
  parameter int STRIDE = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   sel_ctl,
  output logic [N_CH-1:0]   sel_cmp,
  output logic [N_CH-1:0]   sel_val
);
  import tmr_pkg::*;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int BASE = BASE0 + i * STRIDE;
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BASE + OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(BASE + OFS_CMP);
    localparam logic [ADDR_W-1:0] A_VAL = ADDR_W'(BASE + OFS_VAL);
    assign sel_ctl[i] = (addr == A_CTL);
    assign sel_cmp[i] = (addr == A_CMP);
    assign sel_val[i] = (addr == A_VAL);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctl,
  input  logic           wr_cmp,
  input  logic           wr_val,
  input  logic [CW-1:0]  wdata,
  output tmr_pkg::ctl_t  ctl_q,
  output logic [CW-1:0]  cmp_q,
  output logic [CW-1:0]  cnt_q,
  output logic           irq
);
  import tmr_pkg::*;

  logic match;
  logic clr_req;

  assign match   = ctl_q.cen && (cnt_q == cmp_q);
  assign clr_req = wr_ctl && wdata[BIT_PEND];

  // control word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_q.ien <= wdata[BIT_IEN];
        ctl_q.cen <= wdata[BIT_CEN];
      end
      if (match)        ctl_q.pend <= 1'b1;
      else if (clr_req) ctl_q.pend <= 1'b0;
    end
  end

  // compare register
  always_ff @(posedge clk) begin
    if (!rst_n)      cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata;
  end

  // counter: load wins over increment, wraps naturally
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (wr_val)    cnt_q <= wdata;
    else if (ctl_q.cen) cnt_q <= cnt_q + 1'b1;
  end

  assign irq = ctl_q.pend & ctl_q.ien;

  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.cen && !wr_val) |=> (cnt_q == $past(cnt_q) + 1'b1));
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.cen && !wr_val) |=> $stable(cnt_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_val |=> (cnt_q == $past(wdata)));
  assert_pend_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.pend) |-> $past(ctl_q.cen && (cnt_q == cmp_q)));
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !match) |=> !ctl_q.pend);
  assert_w0_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wdata[BIT_PEND] && ctl_q.pend) |=> ctl_q.pend);
  assert_match_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (match && clr_req) |=> ctl_q.pend);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int ADDR_W = 8,
  parameter int N_CH   = 2,
  parameter int BASE0  = 8,
  parameter int STRIDE = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [N_CH-1:0]   irq_o
);
  import tmr_pkg::*;

  localparam int CTL_W = $bits(ctl_t);

  logic [N_CH-1:0] sel_ctl, sel_cmp, sel_val;
  logic            do_wr, do_rd;
  ctl_t            ctl_v [N_CH];
  logic [DW-1:0]   cmp_v [N_CH];
  logic [DW-1:0]   cnt_v [N_CH];
  logic [DW-1:0]   rd_mux;

  assign do_wr = req_valid &  req_write;
  assign do_rd = req_valid & !req_write;

  tmr_decode #(
    .ADDR_W(ADDR_W), .N_CH(N_CH), .BASE0(BASE0), .STRIDE(STRIDE)
  ) u_dec (
    .addr(req_addr), .sel_ctl(sel_ctl), .sel_cmp(sel_cmp), .sel_val(sel_val)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_channel #(.CW(DW)) u_ch (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_ctl(do_wr & sel_ctl[i]),
      .wr_cmp(do_wr & sel_cmp[i]),
      .wr_val(do_wr & sel_val[i]),
      .wdata (req_wdata),
      .ctl_q (ctl_v[i]),
      .cmp_q (cmp_v[i]),
      .cnt_q (cnt_v[i]),
      .irq   (irq_o[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel_ctl[i]) rd_mux = rd_mux | {{(DW-CTL_W){1'b0}}, ctl_v[i]};
      if (sel_cmp[i]) rd_mux = rd_mux | cmp_v[i];
      if (sel_val[i]) rd_mux = rd_mux | cnt_v[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_rdata <= rd_mux;
    end
  end

  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    do_rd |=> rsp_valid);
  assert_rsp_only_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(do_rd));
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && !(|{sel_ctl, sel_cmp, sel_val})) |=> (rsp_rdata == '0));
  assert_decode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ctl, sel_cmp, sel_val}));
endmodule

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  irq_o;

  always #4 clk = ~clk;

  dual_cmp_timer u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // driver: push expectation, issue read
  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.data = e; x.tag = tag;
    q.push_back(x);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic [1:0] e, input string tag);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, e);
    end
  endtask

  // monitor: pop and compare read responses
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t x;
        x = q.pop_front();
        if (rsp_rdata !== x.data) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", x.tag, rsp_rdata, x.data);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk_irq(2'b00, "R11 reset");
    bus_rd(8'h08, 32'h0, "R11 ctl0 reset");
    bus_rd(8'h14, 32'h0, "R11 ctl1 reset");
    bus_rd(8'h1C, 32'h0, "R11 cnt1 reset");

    // R10 unmapped reads zero, writes ignored
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_wr(8'h20, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'h0, "R10 unmapped 0x00");
    bus_rd(8'h20, 32'h0, "R10 unmapped 0x20");
    bus_rd(8'h09, 32'h0, "R10 misaligned 0x09");
    chk_irq(2'b00, "R10 unmapped write no effect");

    // R1 compare registers at their offsets
    bus_wr(8'h0C, 32'h0000_A5A5);
    bus_wr(8'h18, 32'h1234_5678);
    bus_rd(8'h0C, 32'h0000_A5A5, "R1 cmp0");
    bus_rd(8'h18, 32'h1234_5678, "R1 cmp1");

    // R3 R4 channel 0 as time base: 100 + 10 edges
    bus_wr(8'h10, 32'd100);
    bus_wr(8'h08, 32'h4);
    repeat (9) @(negedge clk);
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h10, 32'd110, "R3 cnt0 after 10 edges");
    bus_rd(8'h10, 32'd110, "R3 cnt0 holds when stopped");
    bus_rd(8'h08, 32'h0, "R2 ctl0 stopped");

    // R5 R9 channel 1 one-shot, cmp 5
    bus_wr(8'h1C, 32'd0);
    bus_wr(8'h18, 32'd5);
    bus_wr(8'h14, 32'h6);
    repeat (5) @(negedge clk);
    chk_irq(2'b00, "R5 before match");
    @(negedge clk);
    chk_irq(2'b10, "R9 irq after match");
    bus_wr(8'h14, 32'h2);                 // stop, keep ien, bit0 = 0
    bus_rd(8'h1C, 32'd7, "R5 counter ran past match");
    bus_rd(8'h14, 32'h3, "R7 write zero keeps pending");
    chk_irq(2'b10, "R9 irq level held");
    bus_wr(8'h14, 32'h0);
    chk_irq(2'b00, "R9 irq drops with ien");
    bus_rd(8'h14, 32'h1, "R2 pending kept without ien");
    bus_wr(8'h14, 32'h1);
    bus_rd(8'h14, 32'h0, "R7 w1c clears");

    // R8 match and clear in same cycle, cmp 3
    bus_wr(8'h1C, 32'd0);
    bus_wr(8'h18, 32'd3);
    bus_wr(8'h14, 32'h6);
    repeat (3) @(negedge clk);
    bus_wr(8'h14, 32'h7);
    bus_rd(8'h14, 32'h7, "R8 match beats clear");
    bus_wr(8'h14, 32'h3);
    bus_rd(8'h14, 32'h2, "R7 clear off match cycle");
    chk_irq(2'b00, "R7 irq low after clear");

    // R6 wrap
    bus_wr(8'h1C, 32'hFFFF_FFFE);
    bus_wr(8'h18, 32'h0);
    bus_wr(8'h14, 32'h6);
    repeat (2) @(negedge clk);
    chk_irq(2'b00, "R6 before wrap match");
    @(negedge clk);
    chk_irq(2'b10, "R6 match after wrap");
    bus_wr(8'h14, 32'h2);
    bus_rd(8'h1C, 32'd2, "R6 counter wrapped");
    bus_wr(8'h14, 32'h1);
    chk_irq(2'b00, "R7 cleared after wrap");

    // R5 R9 channel 0 match with ien = 0
    bus_wr(8'h10, 32'd0);
    bus_wr(8'h0C, 32'd2);
    bus_wr(8'h08, 32'h4);
    repeat (4) @(negedge clk);
    chk_irq(2'b00, "R9 no irq without ien");
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h08, 32'h1, "R5 pending set without ien");
    bus_wr(8'h08, 32'h2);
    chk_irq(2'b01, "R9 irq once ien set");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing responses actual=%0d expected=0", q.size());
    end
    done = 1;
    report();
  end
endmodule